// File: doc/BRIEF.md
# Complementary PWM Dead-Time and Pin Gating Stage

This block sits between a timer that generates raw PWM levels and the output pins. For each of four raw PWM channels it produces a pair of outputs: a true output that follows the raw level and an inverse output that follows its complement. When the raw level changes, the output that must go low drops on the next clock edge. Its partner stays low for a programmable number of clock cycles before it is allowed to rise, so the two outputs of a pair are never high together. A single dead-time setting, from 0 to 15 cycles, applies to every pair.

After dead-time insertion, each of the eight pin levels passes through a gate. A gating-mode selector can combine the pin with its own port data bit through an AND or an OR. This lets software force a pin low (AND with 0) or high (OR with 1) whatever the PWM state. One selector governs the four true outputs and a second governs the four inverse outputs.

Top module: `pwm_deadtime_gate`

## Requirements
- R1: While reset is low, and after reset until a pair's raw input first goes high, both dead-timed outputs of that pair are low. With pass-through gating, its pins therefore read 0.
- R2: With a dead-time of 0, the true output of a pair equals the raw input sampled at the previous clock edge, and the inverse output equals its complement, with no gap between them (once the pair has seen its first high raw level).
- R3: With a dead-time of D > 0, suppose the raw input is sampled high at edge k after being low. The true output rises after edge k+D, provided the raw input stays high at every edge from k to k+D. The same rule applies to the inverse output when the raw input goes low.
- R4: The true and inverse dead-timed outputs of a pair are never high at the same time.
- R5: One dead-time value is shared: every pair applies the same D at the same time.
- R6: If the raw input changes again before the dead-time count ends, the pending rise is cancelled. Counting restarts from the new change, in the new direction.
- R7: The output that must fall does so right after the clock edge that first samples the raw change, with no dead-time.
- R8: Gating code 01 (AND) drives each pin to its dead-timed level ANDed with its port bit, so a port bit of 0 forces the pin low.
- R9: Gating code 10 (OR) drives each pin to its dead-timed level ORed with its port bit, so a port bit of 1 forces the pin high.
- R10: Gating codes 00 and 11 pass the dead-timed level to the pin unchanged, and the port bits have no effect.
- R11: `mode_true` gates pins 3..0 (true outputs of pairs 0..3) using port bits 3..0. `mode_inv` gates pins 7..4 (inverse outputs of pairs 0..3) using port bits 7..4. Gating is applied after dead-time, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_raw | input | 4 | Raw PWM levels, one per pair, synchronous to clk |
| dead_cycles | input | 4 | Shared dead-time in clock cycles (0 to 15) |
| mode_true | input | 2 | Gating selector for the true outputs (00/11 pass, 01 AND, 10 OR) |
| mode_inv | input | 2 | Gating selector for the inverse outputs |
| port_bits | input | 8 | Per-pin gating data, bit i for pin i |
| pin_out | output | 8 | Gated pin levels: [3:0] true outputs, [7:4] inverse outputs |

## Verification
Directed edges on a single pair, at dead-times 0, 5 and 6, separate three behaviours: immediate complementary switching, the exact cycle of the delayed rise, and cancellation when the raw input flips back mid-count. Four pairs switched together, and then random per-pair toggling under many randomly chosen dead-times, show that one setting drives every pair alike and that no pair ever overlaps. Each gating code is tried with random port bits while the PWM keeps running, including split selectors for the true and inverse groups. This tells forced-low, forced-high and pass-through apart, and shows that each selector only reaches its own half of the pins.

// File: rtl/pwm_dt_pkg.sv
// Package: shared gating-mode encoding and the per-pin gate function.
// Assumes the 2-bit selector codes listed in gate_mode_e.
package pwm_dt_pkg;

    typedef enum logic [1:0] {
        GATE_PASS     = 2'b00,
        GATE_AND      = 2'b01,
        GATE_OR       = 2'b10,
        GATE_PASS_ALT = 2'b11
    } gate_mode_e;

    // Combine one dead-timed level with its port data bit per the mode.
    function automatic logic apply_gate(input logic [1:0] mode,
                                        input logic       lvl,
                                        input logic       force_bit);
        logic res;
        case (gate_mode_e'(mode))
            GATE_AND: res = lvl & force_bit;
            GATE_OR:  res = lvl | force_bit;
            default:  res = lvl;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pwm_dt_pair.sv
// Module: dead-time generator for one complementary pair.
// On every change of the raw level the falling output drops at once
// and a down-counter reloads from the shared delay. The rising output
// goes high when the count expires. A new change mid-count restarts it.
// Assumes raw is already synchronous to clk.
module pwm_dt_pair #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [DLY_W-1:0] dly,
    output logic             out_true,
    output logic             out_inv
);

    logic             raw_q;
    logic             armed_q;
    logic             hi_q;
    logic             lo_q;
    logic [DLY_W-1:0] cnt_q;
    logic             chg;
    logic             cnt_done;

    // Detect a change of the raw level against the last sampled one.
    assign chg      = raw ^ raw_q;
    // Count is in its last cycle or already idle.
    assign cnt_done = (cnt_q <= DLY_W'(1));

    // Edge tracking, dead-time counting and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= 1'b0;
            armed_q <= 1'b0;
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
            cnt_q   <= '0;
        end else begin
            raw_q <= raw;
            if (chg) begin
                armed_q <= 1'b1;
                cnt_q   <= dly;
                if (dly == '0) begin
                    hi_q <= raw;
                    lo_q <= ~raw;
                end else begin
                    hi_q <= 1'b0;
                    lo_q <= 1'b0;
                end
            end else begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - DLY_W'(1);
                end
                if (armed_q && cnt_done) begin
                    hi_q <= raw_q;
                    lo_q <= ~raw_q;
                end
            end
        end
    end

    assign out_true = hi_q;
    assign out_inv  = lo_q;

endmodule

// File: rtl/pwm_pin_gate.sv
// Module: combinational AND/OR/pass gate over a group of pins that
// share one mode selector. Assumes one port bit per pin.
module pwm_pin_gate #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lvl,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] force_bits,
    output logic [WIDTH-1:0] pin
);

    import pwm_dt_pkg::*;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Gate one pin with its own port bit.
        always_comb pin[g] = apply_gate(mode, lvl[g], force_bits[g]);
    end

endmodule

// File: rtl/pwm_deadtime_gate.sv
// Module: top of the complementary PWM output stage.
// Instantiates one dead-time generator per pair, all sharing one delay,
// and gates the true and inverse groups separately with port data bits.
// Pin order: [NUM_PAIRS-1:0] true outputs, upper half inverse outputs.
module pwm_deadtime_gate #(
    parameter int NUM_PAIRS = 4,
    parameter int DLY_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PAIRS-1:0]   pwm_raw,
    input  logic [DLY_W-1:0]       dead_cycles,
    input  logic [1:0]             mode_true,
    input  logic [1:0]             mode_inv,
    input  logic [2*NUM_PAIRS-1:0] port_bits,
    output logic [2*NUM_PAIRS-1:0] pin_out
);

    localparam int NUM_PINS = 2 * NUM_PAIRS;

    logic [NUM_PAIRS-1:0] dt_true;
    logic [NUM_PAIRS-1:0] dt_inv;
    logic [NUM_PINS-1:0]  gated;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pwm_dt_pair #(.DLY_W(DLY_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (pwm_raw[p]),
            .dly      (dead_cycles),
            .out_true (dt_true[p]),
            .out_inv  (dt_inv[p])
        );
    end

    pwm_pin_gate #(.WIDTH(NUM_PAIRS)) u_gate_true (
        .lvl        (dt_true),
        .mode       (mode_true),
        .force_bits (port_bits[NUM_PAIRS-1:0]),
        .pin        (gated[NUM_PAIRS-1:0])
    );

    pwm_pin_gate #(.WIDTH(NUM_PAIRS)) u_gate_inv (
        .lvl        (dt_inv),
        .mode       (mode_inv),
        .force_bits (port_bits[NUM_PINS-1:NUM_PAIRS]),
        .pin        (gated[NUM_PINS-1:NUM_PAIRS])
    );

    assign pin_out = gated;

endmodule

// File: rtl/pwm_dt_checker.sv
// Module: assertion checker attached to pwm_deadtime_gate by bind.
// Observes the dead-timed levels between the pair and gate stages.
module pwm_dt_checker #(
    parameter int NUM_PAIRS = 4,
    parameter int DLY_W     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PAIRS-1:0]   pwm_raw,
    input logic [NUM_PAIRS-1:0]   dt_true,
    input logic [NUM_PAIRS-1:0]   dt_inv,
    input logic [1:0]             mode_true,
    input logic [1:0]             mode_inv,
    input logic [2*NUM_PAIRS-1:0] port_bits,
    input logic [2*NUM_PAIRS-1:0] pin_out
);

    localparam int N = NUM_PAIRS;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_true & dt_inv) == '0);  // R4
    AST_TRUE_FALLS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dt_true & ~$past(pwm_raw)) == '0);  // R7
    AST_INV_FALLS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dt_inv & $past(pwm_raw)) == '0);  // R7
    AST_AND_FORCES_LOW_T: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_true == 2'b01) |-> (pin_out[N-1:0] & ~port_bits[N-1:0]) == '0);  // R8
    AST_AND_FORCES_LOW_I: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_inv == 2'b01) |-> (pin_out[2*N-1:N] & ~port_bits[2*N-1:N]) == '0);  // R8
    AST_OR_FORCES_HIGH_T: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_true == 2'b10) |-> (~pin_out[N-1:0] & port_bits[N-1:0]) == '0);  // R9
    AST_PASS_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_true == 2'b00 || mode_true == 2'b11) |-> pin_out[N-1:0] == dt_true);  // R10

endmodule

bind pwm_deadtime_gate pwm_dt_checker #(
    .NUM_PAIRS (NUM_PAIRS),
    .DLY_W     (DLY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_raw   (pwm_raw),
    .dt_true   (dt_true),
    .dt_inv    (dt_inv),
    .mode_true (mode_true),
    .mode_inv  (mode_inv),
    .port_bits (port_bits),
    .pin_out   (pin_out)
);

// File: tb/sim_pwm_deadtime_gate.sv
// Bench: random and directed stimulus; the expected pins come from a
// sample-history model of the requirements.
module sim_pwm_deadtime_gate;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] raw;
    logic [DW-1:0] dly;
    logic [1:0]    mt;
    logic [1:0]    mi;
    logic [2*NP-1:0] pb;
    logic [2*NP-1:0] pins;

    logic [15:0]   hist [NP];
    logic [NP-1:0] seen;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_deadtime_gate #(.NUM_PAIRS(NP), .DLY_W(DW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_raw     (raw),
        .dead_cycles (dly),
        .mode_true   (mt),
        .mode_inv    (mi),
        .port_bits   (pb),
        .pin_out     (pins)
    );

    function automatic logic gate_fn(logic [1:0] m, logic l, logic b);
        if (m == 2'b01) return l & b;
        if (m == 2'b10) return l | b;
        return l;
    endfunction

    // Expected pins: a side is high once armed and the last D+1 samples agree.
    function automatic logic [2*NP-1:0] expect_pins();
        logic [2*NP-1:0] e;
        for (int i = 0; i < NP; i++) begin
            logic all_hi = 1'b1;
            logic all_lo = 1'b1;
            for (int k = 0; k <= int'(dly); k++) begin
                all_hi &= hist[i][k];
                all_lo &= ~hist[i][k];
            end
            e[i]      = gate_fn(mt, seen[i] & all_hi, pb[i]);
            e[NP + i] = gate_fn(mi, seen[i] & all_lo, pb[NP + i]);
        end
        return e;
    endfunction

    task automatic check_pins(input string tag);
        logic [2*NP-1:0] e;
        e = expect_pins();
        checks++;
        if (pins !== e) begin
            errors++;
            $display("FAIL %s pins=%b expected=%b", tag, pins, e);
        end
    endtask

    task automatic check_bit(input string tag, input int idx, input logic want);
        checks++;
        if (pins[idx] !== want) begin
            errors++;
            $display("FAIL %s pin%0d=%b expected=%b", tag, idx, pins[idx], want);
        end
    endtask

    // One clock: update the model at the edge, check at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        for (int i = 0; i < NP; i++) begin
            if (!rst_n) hist[i] = '0;
            else        hist[i] = {hist[i][14:0], raw[i]};
        end
        if (!rst_n) seen = '0;
        else        seen = seen | raw;
        @(negedge clk);
        check_pins(tag);
        if (mt[0] == mt[1] && mi[0] == mi[1]) begin
            checks++;
            if ((pins[NP-1:0] & pins[2*NP-1:NP]) != '0) begin
                errors++;
                $display("FAIL R4 overlap pins=%b expected=no pair both high", pins);
            end
        end
    endtask

    task automatic settle(input string tag);
        repeat (17) step(tag);
    endtask

    task automatic rand_toggle();
        for (int i = 0; i < NP; i++)
            if ($urandom_range(3) == 0) raw[i] = ~raw[i];
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NP; i++) hist[i] = '0;
        seen = '0;
        raw = '0; dly = '0; mt = 2'b00; mi = 2'b00; pb = '0; rst_n = 1'b0;

        // R1: reset state and quiet after reset.
        repeat (3) step("R1");
        rst_n = 1'b1;
        repeat (4) step("R1");

        // R2: zero dead-time, plain complement.
        raw = 4'b0101; step("R2"); step("R2");
        raw = 4'b1010; step("R2");
        raw = 4'b0110; step("R2");
        check_bit("R2", 1, 1'b1);
        check_bit("R2", NP + 1, 1'b0);
        raw = 4'b0000; settle("R2");

        // R3, R7: one rising edge with dead-time 5.
        dly = 4'd5;
        raw = 4'b0001; step("R7");
        check_bit("R7", NP, 1'b0);
        repeat (4) step("R3");
        check_bit("R3", 0, 1'b0);
        step("R3");
        check_bit("R3", 0, 1'b1);
        settle("R3");

        // R6: flip back mid-count with dead-time 6.
        dly = 4'd6;
        raw[0] = 1'b0; step("R6"); step("R6");
        raw[0] = 1'b1; step("R6"); step("R6"); step("R6");
        check_bit("R6", 0, 1'b0);
        check_bit("R6", NP, 1'b0);
        repeat (10) step("R6");
        check_bit("R6", 0, 1'b1);

        // R5: all pairs switch together under one shared delay.
        dly = 4'd3;
        raw = 4'b0000; settle("R5");
        raw = 4'b1111; repeat (6) step("R5");
        raw = 4'b0000; repeat (6) step("R5");

        // R8..R11: gating codes with running PWM and random port bits.
        dly = 4'd2;
        mt = 2'b01; mi = 2'b01;
        repeat (25) begin rand_toggle(); pb = 8'($urandom); step("R8"); end
        mt = 2'b10; mi = 2'b10;
        repeat (25) begin rand_toggle(); pb = 8'($urandom); step("R9"); end
        mt = 2'b11; mi = 2'b00;
        repeat (25) begin rand_toggle(); pb = 8'($urandom); step("R10"); end
        mt = 2'b01; mi = 2'b10;
        repeat (25) begin rand_toggle(); pb = 8'($urandom); step("R11"); end
        mt = 2'b10; mi = 2'b11;
        repeat (25) begin rand_toggle(); pb = 8'($urandom); step("R11"); end

        // R5: random phases with a random shared delay each.
        for (int ph = 0; ph < 24; ph++) begin
            mt = 2'($urandom); mi = 2'($urandom);
            settle("R5");
            dly = 4'($urandom);
            repeat (70) begin rand_toggle(); pb = 8'($urandom); step("R5"); end
        end

        // R1: reset mid-run with outputs active.
        mt = 2'b00; mi = 2'b00; pb = '0; raw = 4'b1111;
        settle("R1");
        rst_n = 1'b0; step("R1"); step("R1");
        rst_n = 1'b1; raw = 4'b0000; repeat (3) step("R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: run still active=%0d expected=0", 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule